// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Decoder and Destination Matcher

This block keeps the command registers a processor uses to send an inter-processor interrupt and works out whether the local unit is the target of such an interrupt. Software writes a high destination word and then a low command word. Each write of the low word raises a one-cycle send strobe that carries the decoded command: vector, delivery kind, addressing kind, level, trigger and shorthand. It also carries the destination, which is 8 bits in legacy addressing and 32 bits in extended addressing. In extended addressing a separate self-send register takes a bare vector and builds the matching command word itself.

The matcher side is combinational. For a request that arrives with a destination, an addressing kind, a shorthand and a flag saying whether this unit sent it, the block compares the request with its local ID, its logical-ID register and its destination-format register, and drives one hit bit. In legacy addressing the logical-ID and format registers are writable. In extended addressing the logical ID is derived from the local ID and both registers are read-only.

The send outputs form a valid-only stream with no ready input. `send_valid` is high for one cycle per command and the consumer must take it in that cycle, so the block applies no back-pressure. Register selects are: 0 command low, 1 command high, 2 self-send, 3 logical ID, 4 destination format.

Top module: `ipi_unit`

## Requirements
- R1: After reset the command low and high words and the logical-ID register read 0, the format register reads 0xFFFFFFFF (flat), and `send_valid` is low.
- R2: A write to select 0 raises `send_valid` for one cycle, in the cycle after the write edge. The strobe carries vector = bits [7:0], delivery kind = [10:8], logical addressing = bit 11, level = bit 14, trigger = bit 15 and shorthand = [19:18] of the written word. Writes on consecutive cycles give consecutive strobes.
- R3: The stored low word reads back as written except that bit 12 always reads 0.
- R4: The strobe destination is high-word bits [31:24], zero-extended, in legacy addressing, and the full high word in extended addressing.
- R5: In extended addressing a write of vector v to select 2 stores the low word 0x40000 | v[7:0] and sends it (shorthand 1, delivery kind 0). In legacy addressing that write is ignored: no strobe and no change to the low word.
- R6: Shorthand 1 hits only when the self flag is set. Shorthand 2 always hits. Shorthand 3 hits only when the self flag is clear. Shorthand 0 uses the destination.
- R7: Physical addressing (shorthand 0, logical 0) hits when the destination equals the local ID or equals 0xFF. In legacy addressing only the low 8 bits of both are compared.
- R8: In legacy logical addressing with format bits [31:28] = 0xF, the request hits when logical-ID bits [31:24] AND destination [7:0] is nonzero.
- R9: With format bits [31:28] = 0x0, the request hits when the upper nibbles of the logical ID byte and the destination are equal and their lower nibbles share a set bit.
- R10: Any other format value [31:28] never hits in legacy logical addressing.
- R11: In extended addressing the logical-ID register reads ((id & ~0xF) << 16) | (1 << (id & 0xF)). Writes to select 3 or 4 are ignored there and leave the stored legacy values unchanged.
- R12: In extended logical addressing the request hits when the derived logical ID AND the 32-bit destination is nonzero.
- R13: A legacy write to select 3 keeps only bits [31:24]. A legacy write to select 4 keeps bits [31:28] and reads bits [27:0] as ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_mode | input | 1 | 1 selects extended 32-bit addressing |
| local_id | input | 32 | Local unit ID (low 8 bits used in legacy) |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 32 | Read data (combinational) |
| send_valid | output | 1 | One-cycle send strobe |
| send_vector | output | 8 | Decoded vector |
| send_dlv | output | 3 | Decoded delivery kind |
| send_logical | output | 1 | Decoded logical-addressing flag |
| send_level | output | 1 | Decoded level bit |
| send_trig | output | 1 | Decoded trigger bit |
| send_short | output | 2 | Decoded shorthand |
| send_dest | output | 32 | Decoded destination |
| m_dest | input | 32 | Request destination to match |
| m_logical | input | 1 | Request uses logical addressing |
| m_short | input | 2 | Request shorthand |
| m_is_self | input | 1 | Request was sent by this unit |
| m_hit | output | 1 | This unit is a target |

## Verification
The send strobe and its fields are due one cycle after the clock edge that takes the write. The read data and the match hit follow their inputs in the same cycle. The bench drives inputs one time unit after each rising edge and samples at the falling edge, so a registered result is checked half a cycle after the edge that makes it. On every falling edge the bench compares the strobe with a behavioural model advanced on each rising edge. Reads and matches are checked at the falling edge of the cycle in which their inputs were set.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int DATA_W  = 32;
  localparam int VEC_W   = 8;
  localparam int LEG_W   = 8;
  localparam int DLV_W   = 3;
  localparam int SH_W    = 2;
  localparam int POS_DLV = 8;
  localparam int POS_LOG = 11;
  localparam int POS_BSY = 12;
  localparam int POS_LVL = 14;
  localparam int POS_TRG = 15;
  localparam int POS_SH  = 18;
  localparam logic [DATA_W-1:0] SELF_BASE = 32'h0004_0000;
  localparam logic [3:0] FMT_FLAT    = 4'hF;
  localparam logic [3:0] FMT_CLUSTER = 4'h0;

  typedef enum logic [2:0] {
    SEL_CMD_LO = 3'd0,
    SEL_CMD_HI = 3'd1,
    SEL_SELF   = 3'd2,
    SEL_LDEST  = 3'd3,
    SEL_DFMT   = 3'd4
  } ipi_sel_e;

  typedef enum logic [SH_W-1:0] {
    SH_NONE    = 2'd0,
    SH_SELF    = 2'd1,
    SH_ALL_INC = 2'd2,
    SH_ALL_EXC = 2'd3
  } ipi_sh_e;

  typedef struct packed {
    logic [VEC_W-1:0]  vector;
    logic [DLV_W-1:0]  dlv;
    logic              logical;
    logic              level;
    logic              trig;
    logic [SH_W-1:0]   sh;
    logic [DATA_W-1:0] dest;
  } ipi_cmd_t;

  function automatic ipi_cmd_t ipi_decode(input logic [DATA_W-1:0] lo,
                                          input logic [DATA_W-1:0] hi,
                                          input logic ext);
    ipi_cmd_t c;
    c.vector  = lo[VEC_W-1:0];
    c.dlv     = lo[POS_DLV +: DLV_W];
    c.logical = lo[POS_LOG];
    c.level   = lo[POS_LVL];
    c.trig    = lo[POS_TRG];
    c.sh      = lo[POS_SH +: SH_W];
    c.dest    = ext ? hi : {{(DATA_W-LEG_W){1'b0}}, hi[DATA_W-1 -: LEG_W]};
    return c;
  endfunction
endpackage

// File: rtl/ipi_cmd_regs.sv
module ipi_cmd_regs
  import ipi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_mode,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] cmd_lo,
  output logic [DATA_W-1:0] cmd_hi,
  output logic              send_valid,
  output ipi_cmd_t          send_cmd
);
  localparam logic [DATA_W-1:0] BSY_CLR = ~(DATA_W'(1) << POS_BSY);

  logic [DATA_W-1:0] self_word;
  assign self_word = SELF_BASE | {{(DATA_W-VEC_W){1'b0}}, wr_data[VEC_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_lo     <= '0;
      cmd_hi     <= '0;
      send_valid <= 1'b0;
      send_cmd   <= '0;
    end else begin
      send_valid <= 1'b0;
      if (wr_en) begin
        case (ipi_sel_e'(wr_sel))
          SEL_CMD_LO: begin
            cmd_lo     <= wr_data & BSY_CLR;
            send_valid <= 1'b1;
            send_cmd   <= ipi_decode(wr_data, cmd_hi, ext_mode);
          end
          SEL_CMD_HI: cmd_hi <= wr_data;
          SEL_SELF: begin
            if (ext_mode) begin
              cmd_lo     <= self_word;
              send_valid <= 1'b1;
              send_cmd   <= ipi_decode(self_word, cmd_hi, ext_mode);
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ipi_id_regs.sv
module ipi_id_regs
  import ipi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_mode,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [LEG_W-1:0]  wr_top,
  input  logic [15:0]       id_low,
  output logic [DATA_W-1:0] ldest_view,
  output logic [DATA_W-1:0] dfmt_view,
  output logic [LEG_W-1:0]  leg_lid,
  output logic [3:0]        fmt_model,
  output logic [DATA_W-1:0] ext_lid
);
  localparam int LOW_W = DATA_W - LEG_W;

  logic [LEG_W-1:0] lid_q;
  logic [3:0]       fmt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lid_q <= '0;
      fmt_q <= FMT_FLAT;
    end else if (wr_en && !ext_mode) begin
      if (ipi_sel_e'(wr_sel) == SEL_LDEST) lid_q <= wr_top;
      if (ipi_sel_e'(wr_sel) == SEL_DFMT)  fmt_q <= wr_top[LEG_W-1 -: 4];
    end
  end

  logic [15:0] one_hot;
  always_comb begin
    one_hot = '0;
    one_hot[id_low[3:0]] = 1'b1;
  end

  assign ext_lid    = {id_low[15:4], 4'b0000, one_hot};
  assign leg_lid    = lid_q;
  assign fmt_model  = fmt_q;
  assign ldest_view = ext_mode ? ext_lid : {lid_q, {LOW_W{1'b0}}};
  assign dfmt_view  = {fmt_q, {(DATA_W-4){1'b1}}};
endmodule

// File: rtl/ipi_dest_match.sv
module ipi_dest_match
  import ipi_pkg::*;
(
  input  logic              ext_mode,
  input  logic [DATA_W-1:0] local_id,
  input  logic [LEG_W-1:0]  leg_lid,
  input  logic [3:0]        fmt_model,
  input  logic [DATA_W-1:0] ext_lid,
  input  logic [DATA_W-1:0] m_dest,
  input  logic              m_logical,
  input  logic [SH_W-1:0]   m_short,
  input  logic              m_is_self,
  output logic              m_hit
);
  localparam logic [LEG_W-1:0] BCAST = '1;

  logic phys_hit, flat_hit, clus_hit, leg_log_hit, ext_log_hit, dest_hit;
  logic [LEG_W-1:0] mda;

  assign mda = m_dest[LEG_W-1:0];

  always_comb begin
    if (ext_mode)
      phys_hit = (m_dest == local_id) || (m_dest == {{(DATA_W-LEG_W){1'b0}}, BCAST});
    else
      phys_hit = (mda == local_id[LEG_W-1:0]) || (mda == BCAST);
  end

  assign flat_hit    = |(leg_lid & mda);
  assign clus_hit    = (leg_lid[7:4] == mda[7:4]) && (|(leg_lid[3:0] & mda[3:0]));
  assign ext_log_hit = |(ext_lid & m_dest);

  always_comb begin
    case (fmt_model)
      FMT_FLAT:    leg_log_hit = flat_hit;
      FMT_CLUSTER: leg_log_hit = clus_hit;
      default:     leg_log_hit = 1'b0;
    endcase
  end

  assign dest_hit = !m_logical ? phys_hit : (ext_mode ? ext_log_hit : leg_log_hit);

  always_comb begin
    case (ipi_sh_e'(m_short))
      SH_NONE:    m_hit = dest_hit;
      SH_SELF:    m_hit = m_is_self;
      SH_ALL_INC: m_hit = 1'b1;
      default:    m_hit = !m_is_self;
    endcase
  end
endmodule

// File: rtl/ipi_unit.sv
module ipi_unit
  import ipi_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_mode,
  input  logic [31:0] local_id,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_sel,
  output logic [31:0] rd_data,
  output logic        send_valid,
  output logic [7:0]  send_vector,
  output logic [2:0]  send_dlv,
  output logic        send_logical,
  output logic        send_level,
  output logic        send_trig,
  output logic [1:0]  send_short,
  output logic [31:0] send_dest,
  input  logic [31:0] m_dest,
  input  logic        m_logical,
  input  logic [1:0]  m_short,
  input  logic        m_is_self,
  output logic        m_hit
);
  logic [DATA_W-1:0] cmd_lo, cmd_hi, ldest_view, dfmt_view, ext_lid;
  logic [LEG_W-1:0]  leg_lid;
  logic [3:0]        fmt_model;
  ipi_cmd_t          send_cmd;

  ipi_cmd_regs u_cmd (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cmd_lo(cmd_lo), .cmd_hi(cmd_hi),
    .send_valid(send_valid), .send_cmd(send_cmd)
  );

  ipi_id_regs u_ids (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_top(wr_data[DATA_W-1 -: LEG_W]),
    .id_low(local_id[15:0]),
    .ldest_view(ldest_view), .dfmt_view(dfmt_view),
    .leg_lid(leg_lid), .fmt_model(fmt_model), .ext_lid(ext_lid)
  );

  ipi_dest_match u_match (
    .ext_mode(ext_mode), .local_id(local_id),
    .leg_lid(leg_lid), .fmt_model(fmt_model), .ext_lid(ext_lid),
    .m_dest(m_dest), .m_logical(m_logical), .m_short(m_short),
    .m_is_self(m_is_self), .m_hit(m_hit)
  );

  always_comb begin
    case (ipi_sel_e'(rd_sel))
      SEL_CMD_LO: rd_data = cmd_lo;
      SEL_CMD_HI: rd_data = cmd_hi;
      SEL_LDEST:  rd_data = ldest_view;
      SEL_DFMT:   rd_data = dfmt_view;
      default:    rd_data = '0;
    endcase
  end

  assign send_vector  = send_cmd.vector;
  assign send_dlv     = send_cmd.dlv;
  assign send_logical = send_cmd.logical;
  assign send_level   = send_cmd.level;
  assign send_trig    = send_cmd.trig;
  assign send_short   = send_cmd.sh;
  assign send_dest    = send_cmd.dest;
endmodule

// File: rtl/ipi_unit_chk.sv
module ipi_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ext_mode,
  input logic        wr_en,
  input logic [2:0]  wr_sel,
  input logic [2:0]  rd_sel,
  input logic [31:0] rd_data,
  input logic        send_valid,
  input logic [2:0]  send_dlv,
  input logic [1:0]  send_short,
  input logic [31:0] m_dest,
  input logic        m_logical,
  input logic [1:0]  m_short,
  input logic        m_is_self,
  input logic        m_hit
);
  // R2
  strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    send_valid |-> $past(wr_en && (wr_sel == 3'd0 || (wr_sel == 3'd2 && ext_mode))));

  // R5
  self_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (send_valid && $past(wr_sel == 3'd2)) |-> (send_short == 2'd1 && send_dlv == 3'd0));

  // R3
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == 3'd0) |-> !rd_data[12]);

  // R6
  all_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_short == 2'd2) |-> m_hit);

  // R6
  self_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_short == 2'd1 || m_short == 2'd3) |-> (m_hit == ((m_short == 2'd1) == m_is_self)));

  // R7
  bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_short == 2'd0 && !m_logical && m_dest == 32'hFF) |-> m_hit);

  // R11
  ext_lid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && rd_sel == 3'd3) |-> ($countones(rd_data[15:0]) == 1 && rd_data[19:16] == 4'h0));
endmodule

bind ipi_unit ipi_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .wr_en(wr_en), .wr_sel(wr_sel),
  .rd_sel(rd_sel), .rd_data(rd_data), .send_valid(send_valid), .send_dlv(send_dlv),
  .send_short(send_short), .m_dest(m_dest), .m_logical(m_logical), .m_short(m_short),
  .m_is_self(m_is_self), .m_hit(m_hit)
);

// File: tb/ipi_unit_tb.sv
module ipi_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, ext_mode = 1'b0;
  logic [31:0] local_id = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0, rd_sel = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic        send_valid, send_logical, send_level, send_trig;
  logic [7:0]  send_vector;
  logic [2:0]  send_dlv;
  logic [1:0]  send_short;
  logic [31:0] send_dest;
  logic [31:0] m_dest = '0;
  logic        m_logical = 1'b0, m_is_self = 1'b0, m_hit;
  logic [1:0]  m_short = '0;

  int errs = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_unit u_dut (.*);

  // behavioural model
  logic [31:0] r_lo, r_hi, r_ldr, r_dfr;
  logic        e_valid, e_log, e_lvl, e_trg;
  logic [7:0]  e_vec;
  logic [2:0]  e_dlv;
  logic [1:0]  e_sh;
  logic [31:0] e_dst;

  task automatic model_send(input logic [31:0] w);
    e_valid <= 1'b1;
    e_vec <= w[7:0]; e_dlv <= w[10:8]; e_log <= w[11];
    e_lvl <= w[14]; e_trg <= w[15]; e_sh <= w[19:18];
    e_dst <= ext_mode ? r_hi : (r_hi >> 24);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      r_lo <= 0; r_hi <= 0; r_ldr <= 0; r_dfr <= 32'hFFFF_FFFF;
      e_valid <= 0; e_vec <= 0; e_dlv <= 0; e_log <= 0; e_lvl <= 0;
      e_trg <= 0; e_sh <= 0; e_dst <= 0;
    end else begin
      e_valid <= 1'b0;
      if (wr_en) begin
        if (wr_sel == 0) begin r_lo <= wr_data & ~32'h1000; model_send(wr_data); end
        else if (wr_sel == 1) r_hi <= wr_data;
        else if (wr_sel == 2 && ext_mode) begin
          r_lo <= 32'h40000 | (wr_data & 32'hFF);
          model_send(32'h40000 | (wr_data & 32'hFF));
        end
        else if (wr_sel == 3 && !ext_mode) r_ldr <= wr_data & 32'hFF00_0000;
        else if (wr_sel == 4 && !ext_mode) r_dfr <= wr_data | 32'h0FFF_FFFF;
      end
    end
  end

  function automatic logic [31:0] ext_ldr();
    return ((local_id & ~32'hF) << 16) | (32'h1 << (local_id & 32'hF));
  endfunction

  function automatic logic [31:0] ref_read(input logic [2:0] s);
    case (s)
      0: return r_lo;
      1: return r_hi;
      3: return ext_mode ? ext_ldr() : r_ldr;
      4: return r_dfr;
      default: return 0;
    endcase
  endfunction

  function automatic logic ref_hit(input logic [31:0] d, input logic lg,
                                   input logic [1:0] sh, input logic sf);
    int lid, mda, fm;
    if (sh == 1) return sf;
    if (sh == 2) return 1;
    if (sh == 3) return !sf;
    if (!lg) begin
      if (ext_mode) return (d == local_id) || (d == 32'hFF);
      return ((d & 255) == (local_id & 255)) || ((d & 255) == 255);
    end
    if (ext_mode) return (ext_ldr() & d) != 0;
    lid = int'(r_ldr >> 24); mda = int'(d & 255); fm = int'(r_dfr >> 28);
    if (fm == 15) return (lid & mda) != 0;
    if (fm == 0) return ((lid >> 4) == (mda >> 4)) && ((lid & mda & 15) != 0);
    return 0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // every-clock comparison of the send stream (R2, R4)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 send_valid", {31'b0, send_valid}, {31'b0, e_valid});
      if (e_valid) begin
        check("R2 vector", {24'b0, send_vector}, {24'b0, e_vec});
        check("R2 dlv", {29'b0, send_dlv}, {29'b0, e_dlv});
        check("R2 flags", {29'b0, send_logical, send_level, send_trig}, {29'b0, e_log, e_lvl, e_trg});
        check("R2 shorthand", {30'b0, send_short}, {30'b0, e_sh});
        check("R4 dest", send_dest, e_dst);
      end
    end
  end

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(posedge clk); #1 wr_en = 1; wr_sel = s; wr_data = d;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] s);
    @(posedge clk); #1 rd_sel = s;
    @(negedge clk); check(req, rd_data, ref_read(s));
  endtask

  task automatic mt(input string req, input logic [31:0] d, input logic lg,
                    input logic [1:0] sh, input logic sf);
    @(posedge clk); #1 m_dest = d; m_logical = lg; m_short = sh; m_is_self = sf;
    @(negedge clk); check(req, {31'b0, m_hit}, {31'b0, ref_hit(d, lg, sh, sf)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1 send_valid", {31'b0, send_valid}, 32'h0);
    rd_chk("R1 cmd_lo", 0); rd_chk("R1 cmd_hi", 1);
    rd_chk("R1 ldest", 3);  rd_chk("R1 dfmt", 4);

    // legacy send, bit 12 written as 1
    wr(1, 32'hAB12_3456);
    wr(0, 32'h000C_DF31);
    rd_chk("R3 busy bit", 0);
    rd_chk("R4 cmd_hi", 1);
    // back-to-back low writes
    @(posedge clk); #1 wr_en = 1; wr_sel = 0; wr_data = 32'h0008_4A02;
    @(posedge clk); #1 wr_data = 32'h0004_1103;
    @(posedge clk); #1 wr_en = 0;
    // legacy self-send ignored
    wr(2, 32'h0000_0077);
    rd_chk("R5 legacy self ignored", 0);

    // extended send and self-send
    ext_mode = 1;
    wr(1, 32'h1234_5678);
    wr(0, 32'h0000_1922);
    wr(2, 32'h0000_01FF);
    rd_chk("R5 self word", 0);

    // shorthand and physical, legacy
    ext_mode = 0; local_id = 32'h0000_0005;
    mt("R7 phys equal", 32'h05, 0, 0, 0);
    mt("R7 phys miss", 32'h06, 0, 0, 0);
    mt("R7 phys bcast", 32'hFF, 0, 0, 0);
    mt("R7 legacy low byte", 32'h0000_0305, 0, 0, 0);
    mt("R6 self flag", 32'h06, 0, 1, 1);
    mt("R6 self clear", 32'h05, 0, 1, 0);
    mt("R6 all inc", 32'h06, 0, 2, 1);
    mt("R6 all exc self", 32'h05, 0, 3, 1);
    mt("R6 all exc other", 32'h06, 0, 3, 0);

    // flat
    wr(3, 32'h2CAB_CDEF);
    rd_chk("R13 ldest top byte", 3);
    mt("R8 flat hit", 32'h04, 1, 0, 0);
    mt("R8 flat miss", 32'h10, 1, 0, 0);
    // cluster
    wr(4, 32'h0123_4567);
    rd_chk("R13 dfmt ones", 4);
    wr(3, 32'h2100_0000);
    mt("R9 cluster hit", 32'h23, 1, 0, 0);
    mt("R9 cluster other cluster", 32'h31, 1, 0, 0);
    mt("R9 cluster no bit", 32'h22, 1, 0, 0);
    // unknown model
    wr(4, 32'h5000_0000);
    mt("R10 bad model", 32'hFF, 1, 0, 0);
    mt("R10 bad model bit", 32'h21, 1, 0, 0);

    // extended logical ID
    ext_mode = 1; local_id = 32'h0000_0013;
    rd_chk("R11 derived ldest", 3);
    wr(3, 32'hFFFF_FFFF);
    wr(4, 32'hF000_0000);
    rd_chk("R11 ldest write ignored", 3);
    rd_chk("R11 dfmt write ignored", 4);
    mt("R12 ext low bit", 32'h0000_0008, 1, 0, 0);
    mt("R12 ext cluster bit", 32'h0010_0000, 1, 0, 0);
    mt("R12 ext miss", 32'h0000_0004, 1, 0, 0);
    mt("R7 ext phys", 32'h13, 0, 0, 0);
    mt("R7 ext wide miss", 32'h113, 0, 0, 0);
    mt("R7 ext bcast", 32'hFF, 0, 0, 0);
    ext_mode = 0;
    rd_chk("R11 legacy ldest kept", 3);
    rd_chk("R11 legacy dfmt kept", 4);

    repeat (3) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule